// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block moves data between an A port and a B port. It is built from identical halves, each `HALF_W` bits wide; by default there are two 8-bit halves that can also work together as one 16-bit path. Each half has its own output enable, direction, two capture inputs and two source selects. Each port is modelled as a separate input bus, output bus and drive-enable vector, so the design has no tri-state pins.

Each half holds two registers. The A-to-B register samples the A port and the B-to-A register samples the B port. A register loads on the first clock edge at which its capture input is seen high after being seen low. Loading never depends on the output enable or on the direction. The output enable and the direction choose at most one port per half to drive. The driven port carries either the live data from the opposite port, through a purely combinational path, or the contents of the register for that direction. With the output enable high, the half is isolated: neither port is driven, but both registers keep capturing.

Top module: `bus_xcvr_reg`

## Requirements
- R1: For each half h, `a_drv[h]` = `!oe_n[h] && !dir[h]` and `b_drv[h]` = `!oe_n[h] && dir[h]`. The two enables of one half are never high together.
- R2: While `oe_n[h]` is 1, both drive enables of half h are 0 and both output slices of half h read zero.
- R3: The A-to-B register of half h loads `a_in[h*HALF_W +: HALF_W]` on a rising `clk` edge where `cap_ab[h]` is 1 and was 0 at the previous edge.
- R4: The B-to-A register of half h loads `b_in[h*HALF_W +: HALF_W]` on a rising `clk` edge where `cap_ba[h]` is 1 and was 0 at the previous edge.
- R5: Capture happens whatever the values of `oe_n` and `dir`, including in isolation and while the captured port is the one being driven.
- R6: While `a_drv[h]` is 1, the A output slice equals the live B input slice when `sel_ba[h]` is 0 and the B-to-A register when `sel_ba[h]` is 1. The switch takes effect in the same cycle, with no clock edge.
- R7: While `b_drv[h]` is 1, the B output slice equals the live A input slice when `sel_ab[h]` is 0 and the A-to-B register when `sel_ab[h]` is 1. The switch takes effect in the same cycle.
- R8: An output slice whose drive enable is 0 reads all zeros.
- R9: A synchronous active-high `rst` clears both registers of every half and clears the capture history. A capture input that is high when reset is released therefore loads on the first edge after release.
- R10: The halves are independent. Half h uses only control bit h and data bits `[h*HALF_W +: HALF_W]`.
- R11: Holding a capture input high over several edges does not reload its register after the first load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the capture inputs |
| rst | input | 1 | Synchronous reset, active high |
| oe_n | input | NUM_HALVES | Output enable per half, active low |
| dir | input | NUM_HALVES | Per half: 1 drives B from A, 0 drives A from B |
| cap_ab | input | NUM_HALVES | Capture input for the A-to-B register |
| cap_ba | input | NUM_HALVES | Capture input for the B-to-A register |
| sel_ab | input | NUM_HALVES | B output source: 0 live A, 1 stored |
| sel_ba | input | NUM_HALVES | A output source: 0 live B, 1 stored |
| a_in | input | NUM_HALVES*HALF_W | Data arriving at the A port |
| a_out | output | NUM_HALVES*HALF_W | Data driven onto the A port |
| a_drv | output | NUM_HALVES | A port drive enable per half |
| b_in | input | NUM_HALVES*HALF_W | Data arriving at the B port |
| b_out | output | NUM_HALVES*HALF_W | Data driven onto the B port |
| b_drv | output | NUM_HALVES | B port drive enable per half |

## Verification
The only internal state is the stored registers and the capture history, and neither is visible at the ports until the matching select is set on a driven port. The bench therefore keeps the stored path selected on many cycles, so a missed load, a spurious reload or a register that reset failed to clear shows up on the first such cycle after the faulty edge. A wrong capture history appears as a load one edge early or late, or as repeated loads while a capture input is held high. Mistakes in the live path or in the drive enables show up in the same cycle as the stimulus, because those paths are combinational.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef struct packed {
    logic oe_n;
    logic dir;
    logic cap_ab;
    logic cap_ba;
    logic sel_ab;
    logic sel_ba;
  } half_ctrl_t;
endpackage

// File: rtl/xcvr_capture.sv
module xcvr_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic cap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q <= 1'b0;
      q_o   <= '0;
    end else begin
      cap_q <= cap_i;
      if (cap_i && !cap_q) q_o <= d_i;
    end
  end
endmodule

// File: rtl/xcvr_half.sv
module xcvr_half
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  half_ctrl_t   ctrl,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] a_o,
  output logic         a_en,
  output logic [W-1:0] b_o,
  output logic         b_en
);
  logic [W-1:0] store_ab;
  logic [W-1:0] store_ba;

  xcvr_capture #(.W(W)) u_cap_ab (
    .clk(clk), .rst(rst), .cap_i(ctrl.cap_ab), .d_i(a_i), .q_o(store_ab)
  );

  xcvr_capture #(.W(W)) u_cap_ba (
    .clk(clk), .rst(rst), .cap_i(ctrl.cap_ba), .d_i(b_i), .q_o(store_ba)
  );

  always_comb begin
    a_en = !ctrl.oe_n && !ctrl.dir;
    b_en = !ctrl.oe_n &&  ctrl.dir;
    a_o  = '0;
    b_o  = '0;
    if (a_en) a_o = ctrl.sel_ba ? store_ba : b_i;
    if (b_en) b_o = ctrl.sel_ab ? store_ab : a_i;
  end
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import xcvr_pkg::*;
#(
  parameter int HALF_W     = 8,
  parameter int NUM_HALVES = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_HALVES-1:0]        oe_n,
  input  logic [NUM_HALVES-1:0]        dir,
  input  logic [NUM_HALVES-1:0]        cap_ab,
  input  logic [NUM_HALVES-1:0]        cap_ba,
  input  logic [NUM_HALVES-1:0]        sel_ab,
  input  logic [NUM_HALVES-1:0]        sel_ba,
  input  logic [NUM_HALVES*HALF_W-1:0] a_in,
  output logic [NUM_HALVES*HALF_W-1:0] a_out,
  output logic [NUM_HALVES-1:0]        a_drv,
  input  logic [NUM_HALVES*HALF_W-1:0] b_in,
  output logic [NUM_HALVES*HALF_W-1:0] b_out,
  output logic [NUM_HALVES-1:0]        b_drv
);
  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    half_ctrl_t ctrl;
    assign ctrl = '{oe_n: oe_n[h], dir: dir[h], cap_ab: cap_ab[h],
                    cap_ba: cap_ba[h], sel_ab: sel_ab[h], sel_ba: sel_ba[h]};

    xcvr_half #(.W(HALF_W)) u_half (
      .clk (clk),
      .rst (rst),
      .ctrl(ctrl),
      .a_i (a_in[h*HALF_W +: HALF_W]),
      .b_i (b_in[h*HALF_W +: HALF_W]),
      .a_o (a_out[h*HALF_W +: HALF_W]),
      .a_en(a_drv[h]),
      .b_o (b_out[h*HALF_W +: HALF_W]),
      .b_en(b_drv[h])
    );
  end
endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
  parameter int HALF_W     = 8,
  parameter int NUM_HALVES = 2
) (
  input logic                         clk,
  input logic                         rst,
  input logic [NUM_HALVES-1:0]        oe_n,
  input logic [NUM_HALVES-1:0]        dir,
  input logic [NUM_HALVES-1:0]        cap_ab,
  input logic [NUM_HALVES-1:0]        sel_ab,
  input logic [NUM_HALVES-1:0]        sel_ba,
  input logic [NUM_HALVES*HALF_W-1:0] a_out,
  input logic [NUM_HALVES-1:0]        a_drv,
  input logic [NUM_HALVES*HALF_W-1:0] b_out,
  input logic [NUM_HALVES-1:0]        b_drv
);
  // R1
  single_driver_chk: assert property (@(posedge clk) disable iff (rst)
    (a_drv & b_drv) == '0);

  // R2
  isolation_chk: assert property (@(posedge clk) disable iff (rst)
    ((a_drv | b_drv) & oe_n) == '0);

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_chk
    // R8
    idle_a_zero_chk: assert property (@(posedge clk) disable iff (rst)
      !a_drv[h] |-> a_out[h*HALF_W +: HALF_W] == '0);

    // R9
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) && a_drv[h] && sel_ba[h]) |-> a_out[h*HALF_W +: HALF_W] == '0);

    // R11
    held_capture_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && cap_ab[h] && $past(cap_ab[h]) && b_drv[h] && sel_ab[h])
      |=> (!(b_drv[h] && sel_ab[h]) || $stable(b_out[h*HALF_W +: HALF_W])));
  end
endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.HALF_W(HALF_W), .NUM_HALVES(NUM_HALVES)) u_chk (
  .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir), .cap_ab(cap_ab),
  .sel_ab(sel_ab), .sel_ba(sel_ba), .a_out(a_out), .a_drv(a_drv),
  .b_out(b_out), .b_drv(b_drv)
);

// File: tb/test_bus_xcvr_reg.sv
module test_bus_xcvr_reg;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int H  = 2;
  localparam int DW = W * H;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [H-1:0] oe_n = '1, dir = '0, cap_ab = '0, cap_ba = '0, sel_ab = '0, sel_ba = '0;
  logic [DW-1:0] a_in = '0, b_in = '0;
  logic [DW-1:0] a_out, b_out;
  logic [H-1:0] a_drv, b_drv;

  logic [W-1:0] m_ab [H];
  logic [W-1:0] m_ba [H];
  logic         m_pab [H];
  logic         m_pba [H];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_xcvr_reg #(.HALF_W(W), .NUM_HALVES(H)) i_bus_xcvr_reg (
    .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir), .cap_ab(cap_ab), .cap_ba(cap_ba),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
    .b_in(b_in), .b_out(b_out), .b_drv(b_drv)
  );

  task automatic check(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    logic [DW-1:0] ea, eb;
    logic [H-1:0]  da, db;
    for (int h = 0; h < H; h++) begin
      da[h] = !oe_n[h] && !dir[h];
      db[h] = !oe_n[h] &&  dir[h];
      ea[h*W +: W] = !da[h] ? '0 : (sel_ba[h] ? m_ba[h] : b_in[h*W +: W]);
      eb[h*W +: W] = !db[h] ? '0 : (sel_ab[h] ? m_ab[h] : a_in[h*W +: W]);
    end
    check(req, "a_drv", DW'(a_drv), DW'(da));
    check(req, "b_drv", DW'(b_drv), DW'(db));
    check(req, "a_out", a_out, ea);
    check(req, "b_out", b_out, eb);
    check("R1", "dual drive", DW'(a_drv & b_drv), '0);
  endtask

  // one clock: model follows the edge, returns at the next falling edge
  task automatic tick();
    @(posedge clk);
    #1;
    for (int h = 0; h < H; h++) begin
      if (rst) begin
        m_ab[h] = '0; m_ba[h] = '0; m_pab[h] = 0; m_pba[h] = 0;
      end else begin
        if (cap_ab[h] && !m_pab[h]) m_ab[h] = a_in[h*W +: W];
        if (cap_ba[h] && !m_pba[h]) m_ba[h] = b_in[h*W +: W];
        m_pab[h] = cap_ab[h];
        m_pba[h] = cap_ba[h];
      end
    end
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    n_run++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int h = 0; h < H; h++) begin
      m_ab[h] = 'x; m_ba[h] = 'x; m_pab[h] = 0; m_pba[h] = 0;
    end
    @(negedge clk);
    // R9: toggle captures during reset; nothing may load
    a_in = 16'h5A3C; b_in = 16'hC3A5; cap_ab = '1; cap_ba = '1;
    tick(); tick();
    cap_ab = '0; cap_ba = '0;
    tick();
    rst = 1'b0;
    oe_n = '0; dir = '0; sel_ba = '1;
    #1 check_all("R9");
    dir = '1; sel_ab = '1;
    #1 check_all("R9");

    // R2 + R5 + R3: capture A while isolated
    oe_n = '1; a_in = 16'h1234;
    #1 check_all("R2");
    tick();
    cap_ab = '1;
    tick();
    a_in = 16'hFFFF;
    oe_n = '0; dir = '1; sel_ab = '1;
    #1 check_all("R3");

    // R11: held capture does not reload
    tick();
    #1 check_all("R11");
    a_in = 16'h0F0F;
    tick();
    #1 check_all("R11");

    // R4 + R5: capture B while B is itself the driven port
    cap_ab = '0; b_in = 16'hBEEF; cap_ba = '1;
    tick();
    b_in = 16'h0000; dir = '0; sel_ba = '1;
    #1 check_all("R4");

    // R6 + R7: same-cycle switch between live and stored
    b_in = 16'h7E81;
    sel_ba = '0;
    #1 check_all("R6");
    sel_ba = '1;
    #1 check_all("R6");
    dir = '1; a_in = 16'h9966;
    sel_ab = '0;
    #1 check_all("R7");
    sel_ab = '1;
    #1 check_all("R7");

    // R10: halves in opposite directions with different sources
    dir = 2'b10; sel_ab = 2'b01; sel_ba = 2'b10; cap_ab = 2'b00; cap_ba = 2'b00;
    a_in = 16'hA1B2; b_in = 16'hC3D4;
    #1 check_all("R10");
    tick();
    cap_ab = 2'b10; cap_ba = 2'b01; a_in = 16'h4455; b_in = 16'h6677;
    tick();
    sel_ab = '1; sel_ba = '1;
    #1 check_all("R10");
    oe_n = 2'b01;
    #1 check_all("R8");

    // random patterns on both halves
    for (int i = 0; i < 600; i++) begin
      tick();
      oe_n   = H'($urandom);
      dir    = H'($urandom);
      cap_ab = H'($urandom);
      cap_ba = H'($urandom);
      sel_ab = H'($urandom);
      sel_ba = H'($urandom);
      a_in   = DW'($urandom);
      b_in   = DW'($urandom);
      rst    = ($urandom_range(0, 63) == 0);
      #1 check_all("R6/R7 random");
    end
    rst = 1'b0;
    tick();
    finish_run();
  end
endmodule